// File: doc/BRIEF.md
# Display List Register Loader

This block is a bus master that applies a batch of register writes kept in memory. Software can then reconfigure a video pipeline with one commit instead of many direct register accesses. Each list body is a packed array of 8-byte entries. The engine reads them through a simple request/response memory port and replays each entry as a single write on an internal register bus. It is driven by frame-start and frame-end events and raises two pulse interrupts: one when a list completes, and one when a completed list's memory may be reused.

The block has two modes. In headerless mode, software commits a body address and byte count, and this sets an update flag. At the next frame end the engine takes that list, clears the flag and replays the list at once. With the continuous control bit set, the last list taken is replayed at every frame end while no new commit is waiting.

In header mode, a manual start points the engine at a 76-byte descriptor in memory. The engine reads the first slot's byte count and address and the flags word. It then runs the body either immediately or at the next frame end.

Top module: `reglist_loader`

## Requirements
- R1: After reset the outputs busy, upd_pending, err_sticky, rb_wr, mem_req, irq_done and irq_free are all low.
- R2: In headerless mode (cfg_hdr_mode=0), a cfg_commit pulse while upd_pending is low captures cfg_list_addr and cfg_list_bytes and sets upd_pending on the next cycle. A commit while upd_pending is high changes nothing. In header mode a commit is ignored.
- R3: In headerless mode, a frame_end pulse with upd_pending high and the engine idle takes the captured list: upd_pending is low the next cycle and the replay starts. If upd_pending is low (and continuous mode is off), or if the engine is busy, frame_end takes nothing and upd_pending is unchanged. A commit that lands in the same cycle as frame_end is taken at the following frame_end.
- R4: The entry at body address + 8*i is replayed as the i-th write. The low 32 bits of the 64-bit memory word are the register address and the high 32 bits are the data. Each entry is written exactly once, strictly in order.
- R5: With cfg_continuous=1 in headerless mode, a frame_end with upd_pending low replays the last list taken, if one has been taken.
- R6: In header mode, a cfg_start pulse with the engine idle reads the header at cfg_list_addr. The slot-0 byte count is taken from byte offset 4, the slot-0 body address from byte offset 8 and the flags word from byte offset 72. The list count, the other seven slots and the next-header pointer have no effect.
- R7: Header flags bit 0 set starts the body right after the header is parsed. With bit 0 clear, the engine stays busy with no writes until the next frame_end.
- R8: irq_done pulses for one cycle together with the last write of a list. It pulses for every headerless list, and for a header list only when flags bit 1 is set.
- R9: A list of zero bytes, a byte count that is not a multiple of 8, a count above 256 entries (2048 bytes) or a body address that is not 8-byte aligned produces no writes and sets err_sticky, which stays set until reset. A count of exactly 2048 bytes is replayed in full.
- R10: busy is high from the first memory request of a run through the cycle of its last write, and low when idle.
- R11: irq_free pulses for one cycle, the cycle after a frame_start, when a list has completed since the previous irq_free.
- R12: Every mem_addr presented with mem_req is 8-byte aligned, and mem_req is never high in two consecutive cycles (one read outstanding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hdr_mode | input | 1 | 1 = header mode, 0 = headerless mode |
| cfg_continuous | input | 1 | Replay the last list every frame (headerless mode) |
| cfg_list_addr | input | AW | Body address (headerless) or header address (header mode) |
| cfg_list_bytes | input | BW | Body byte count for a headerless commit |
| cfg_commit | input | 1 | Commit pulse for a headerless list |
| cfg_start | input | 1 | Manual start pulse for header mode |
| frame_start | input | 1 | Frame-start event pulse |
| frame_end | input | 1 | Frame-end event pulse |
| mem_req | output | 1 | Memory read request for one 64-bit word |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response word; byte 0 in bits 7:0 |
| rb_wr | output | 1 | Register bus write strobe |
| rb_addr | output | 32 | Register bus write address |
| rb_data | output | 32 | Register bus write data |
| upd_pending | output | 1 | Update flag: a committed list is waiting for frame end |
| busy | output | 1 | Engine running a header fetch or a body replay |
| err_sticky | output | 1 | Sticky bad-list error |
| irq_done | output | 1 | List-complete interrupt pulse |
| irq_free | output | 1 | List-memory-released interrupt pulse |

## Verification
The sharpest collision is between a software commit and the frame-end capture in the same cycle. The bench raises cfg_commit and frame_end together while no update is pending. It judges that this frame is skipped: upd_pending stays high, no write appears, and the list is replayed only after the next frame_end. A second collision is frame_end arriving while a long 256-entry replay is still running, with a fresh commit pending. The bench checks that upd_pending survives that event and that the pending list runs at the next idle frame end, with the order of every write compared against a scoreboard queue.

// File: rtl/rll_pkg.sv
package rll_pkg;

    localparam int unsigned ENTRY_BYTES   = 8;
    localparam int unsigned REG_W         = 32;
    localparam int unsigned WORD_W        = 2 * REG_W;
    localparam int unsigned HDR_ADDR_OFS  = 8;
    localparam int unsigned HDR_FLAGS_OFS = 72;
    localparam int unsigned FLAG_AUTO_BIT = 0;
    localparam int unsigned FLAG_IRQ_BIT  = 1;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_H0_REQ  = 4'd1,
        ST_H0_WAIT = 4'd2,
        ST_H1_REQ  = 4'd3,
        ST_H1_WAIT = 4'd4,
        ST_HF_REQ  = 4'd5,
        ST_HF_WAIT = 4'd6,
        ST_ARM     = 4'd7,
        ST_B_REQ   = 4'd8,
        ST_B_WAIT  = 4'd9,
        ST_DONE    = 4'd10
    } eng_state_e;

endpackage

// File: rtl/rll_shadow.sv
module rll_shadow #(
    parameter int unsigned AW = 32,
    parameter int unsigned BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hdr_mode,
    input  logic          continuous,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [BW-1:0] commit_bytes,
    input  logic          frame_end,
    input  logic          eng_idle,
    output logic          upd,
    output logic          launch,
    output logic [AW-1:0] run_addr,
    output logic [BW-1:0] run_bytes
);

    typedef struct packed {
        logic          upd;
        logic          have;
        logic [AW-1:0] pend_addr;
        logic [BW-1:0] pend_bytes;
        logic [AW-1:0] act_addr;
        logic [BW-1:0] act_bytes;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    take_c, rerun_c;

    always_comb begin
        sh_d    = sh_q;
        take_c  = !hdr_mode && frame_end && eng_idle && sh_q.upd;
        rerun_c = !hdr_mode && frame_end && eng_idle && !sh_q.upd
                  && continuous && sh_q.have;
        if (take_c) begin
            sh_d.upd       = 1'b0;
            sh_d.have      = 1'b1;
            sh_d.act_addr  = sh_q.pend_addr;
            sh_d.act_bytes = sh_q.pend_bytes;
        end
        if (commit && !hdr_mode && !sh_q.upd) begin
            sh_d.upd        = 1'b1;
            sh_d.pend_addr  = commit_addr;
            sh_d.pend_bytes = commit_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign upd       = sh_q.upd;
    assign launch    = take_c || rerun_c;
    assign run_addr  = take_c ? sh_q.pend_addr  : sh_q.act_addr;
    assign run_bytes = take_c ? sh_q.pend_bytes : sh_q.act_bytes;

endmodule

// File: rtl/rll_engine.sv
module rll_engine
    import rll_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned BW          = 16,
    parameter int unsigned MAX_ENTRIES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_mode,
    input  logic              start,
    input  logic [AW-1:0]     hdr_addr,
    input  logic              launch,
    input  logic [AW-1:0]     run_addr,
    input  logic [BW-1:0]     run_bytes,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rb_wr,
    output logic [REG_W-1:0]  rb_addr,
    output logic [REG_W-1:0]  rb_data,
    output logic              busy,
    output logic              idle,
    output logic              err,
    output logic              irq_done,
    output logic              irq_free
);

    localparam int unsigned MAX_BYTES = MAX_ENTRIES * ENTRY_BYTES;
    localparam int unsigned CW        = $clog2(MAX_ENTRIES + 1);
    localparam int unsigned SHIFT     = $clog2(ENTRY_BYTES);

    typedef struct packed {
        eng_state_e       st;
        logic [AW-1:0]    ptr;
        logic [CW-1:0]    left;
        logic             irq_en;
        logic [AW-1:0]    hdr_base;
        logic [REG_W-1:0] body_bytes;
        logic [AW-1:0]    body_addr;
        logic             rb_wr;
        logic [REG_W-1:0] rb_addr;
        logic [REG_W-1:0] rb_data;
        logic             done_irq;
        logic             err;
        logic             free_pend;
        logic             free_irq;
    } eng_t;

    eng_t eg_d, eg_q;

    function automatic logic list_ok(input logic [REG_W-1:0] nbytes,
                                     input logic [AW-1:0] addr);
        return (nbytes != '0) && (nbytes[SHIFT-1:0] == '0)
               && (nbytes <= REG_W'(MAX_BYTES)) && (addr[SHIFT-1:0] == '0);
    endfunction

    function automatic logic [CW-1:0] entries_of(input logic [REG_W-1:0] nbytes);
        return CW'(nbytes >> SHIFT);
    endfunction

    always_comb begin
        eg_d          = eg_q;
        eg_d.rb_wr    = 1'b0;
        eg_d.done_irq = 1'b0;
        eg_d.free_irq = 1'b0;
        if (frame_start && eg_q.free_pend) begin
            eg_d.free_irq  = 1'b1;
            eg_d.free_pend = 1'b0;
        end
        unique case (eg_q.st)
            ST_IDLE: begin
                if (launch) begin
                    if (list_ok(REG_W'(run_bytes), run_addr)) begin
                        eg_d.st     = ST_B_REQ;
                        eg_d.ptr    = run_addr;
                        eg_d.left   = entries_of(REG_W'(run_bytes));
                        eg_d.irq_en = 1'b1;
                    end else begin
                        eg_d.err = 1'b1;
                    end
                end else if (hdr_mode && start) begin
                    if (hdr_addr[SHIFT-1:0] == '0) begin
                        eg_d.st       = ST_H0_REQ;
                        eg_d.hdr_base = hdr_addr;
                        eg_d.ptr      = hdr_addr;
                    end else begin
                        eg_d.err = 1'b1;
                    end
                end
            end
            ST_H0_REQ: eg_d.st = ST_H0_WAIT;
            ST_H0_WAIT: begin
                if (mem_rvalid) begin
                    eg_d.body_bytes = mem_rdata[WORD_W-1:REG_W];
                    eg_d.ptr        = eg_q.hdr_base + AW'(HDR_ADDR_OFS);
                    eg_d.st         = ST_H1_REQ;
                end
            end
            ST_H1_REQ: eg_d.st = ST_H1_WAIT;
            ST_H1_WAIT: begin
                if (mem_rvalid) begin
                    eg_d.body_addr = mem_rdata[AW-1:0];
                    eg_d.ptr       = eg_q.hdr_base + AW'(HDR_FLAGS_OFS);
                    eg_d.st        = ST_HF_REQ;
                end
            end
            ST_HF_REQ: eg_d.st = ST_HF_WAIT;
            ST_HF_WAIT: begin
                if (mem_rvalid) begin
                    if (list_ok(eg_q.body_bytes, eg_q.body_addr)) begin
                        eg_d.ptr    = eg_q.body_addr;
                        eg_d.left   = entries_of(eg_q.body_bytes);
                        eg_d.irq_en = mem_rdata[FLAG_IRQ_BIT];
                        eg_d.st     = mem_rdata[FLAG_AUTO_BIT] ? ST_B_REQ : ST_ARM;
                    end else begin
                        eg_d.err = 1'b1;
                        eg_d.st  = ST_IDLE;
                    end
                end
            end
            ST_ARM: begin
                if (frame_end) eg_d.st = ST_B_REQ;
            end
            ST_B_REQ: eg_d.st = ST_B_WAIT;
            ST_B_WAIT: begin
                if (mem_rvalid) begin
                    eg_d.rb_wr   = 1'b1;
                    eg_d.rb_addr = mem_rdata[REG_W-1:0];
                    eg_d.rb_data = mem_rdata[WORD_W-1:REG_W];
                    eg_d.ptr     = eg_q.ptr + AW'(ENTRY_BYTES);
                    eg_d.left    = eg_q.left - CW'(1);
                    if (eg_q.left == CW'(1)) begin
                        eg_d.st       = ST_DONE;
                        eg_d.done_irq = eg_q.irq_en;
                    end else begin
                        eg_d.st = ST_B_REQ;
                    end
                end
            end
            ST_DONE: begin
                eg_d.st        = ST_IDLE;
                eg_d.free_pend = 1'b1;
            end
            default: eg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eg_q <= '0;
        else        eg_q <= eg_d;
    end

    assign mem_req  = (eg_q.st == ST_H0_REQ) || (eg_q.st == ST_H1_REQ)
                   || (eg_q.st == ST_HF_REQ) || (eg_q.st == ST_B_REQ);
    assign mem_addr = eg_q.ptr;
    assign rb_wr    = eg_q.rb_wr;
    assign rb_addr  = eg_q.rb_addr;
    assign rb_data  = eg_q.rb_data;
    assign idle     = (eg_q.st == ST_IDLE);
    assign busy     = !idle;
    assign err      = eg_q.err;
    assign irq_done = eg_q.done_irq;
    assign irq_free = eg_q.free_irq;

endmodule

// File: rtl/reglist_loader.sv
module reglist_loader
    import rll_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned BW          = 16,
    parameter int unsigned MAX_ENTRIES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hdr_mode,
    input  logic              cfg_continuous,
    input  logic [AW-1:0]     cfg_list_addr,
    input  logic [BW-1:0]     cfg_list_bytes,
    input  logic              cfg_commit,
    input  logic              cfg_start,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rb_wr,
    output logic [REG_W-1:0]  rb_addr,
    output logic [REG_W-1:0]  rb_data,
    output logic              upd_pending,
    output logic              busy,
    output logic              err_sticky,
    output logic              irq_done,
    output logic              irq_free
);

    logic          eng_idle;
    logic          launch;
    logic [AW-1:0] run_addr;
    logic [BW-1:0] run_bytes;

    rll_shadow #(.AW(AW), .BW(BW)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_mode     (cfg_hdr_mode),
        .continuous   (cfg_continuous),
        .commit       (cfg_commit),
        .commit_addr  (cfg_list_addr),
        .commit_bytes (cfg_list_bytes),
        .frame_end    (frame_end),
        .eng_idle     (eng_idle),
        .upd          (upd_pending),
        .launch       (launch),
        .run_addr     (run_addr),
        .run_bytes    (run_bytes)
    );

    rll_engine #(.AW(AW), .BW(BW), .MAX_ENTRIES(MAX_ENTRIES)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdr_mode    (cfg_hdr_mode),
        .start       (cfg_start),
        .hdr_addr    (cfg_list_addr),
        .launch      (launch),
        .run_addr    (run_addr),
        .run_bytes   (run_bytes),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .rb_wr       (rb_wr),
        .rb_addr     (rb_addr),
        .rb_data     (rb_data),
        .busy        (busy),
        .idle        (eng_idle),
        .err         (err_sticky),
        .irq_done    (irq_done),
        .irq_free    (irq_free)
    );

endmodule

// File: rtl/rll_checker.sv
module rll_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_commit,
    input logic          frame_start,
    input logic          frame_end,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          rb_wr,
    input logic          upd_pending,
    input logic          busy,
    input logic          err_sticky,
    input logic          irq_done,
    input logic          irq_free
);

    assert_upd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pending && !frame_end) |=> upd_pending);

    assert_upd_set_by_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pending && !cfg_commit) |=> !upd_pending);

    assert_irq_with_last_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> rb_wr);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_write_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_wr |-> busy);

    assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_free_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_free |-> $past(frame_start));

    assert_req_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'd0));

    assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

bind reglist_loader rll_checker #(.AW(AW)) u_rll_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_commit  (cfg_commit),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .rb_wr       (rb_wr),
    .upd_pending (upd_pending),
    .busy        (busy),
    .err_sticky  (err_sticky),
    .irq_done    (irq_done),
    .irq_free    (irq_free)
);

// File: tb/test_reglist_loader.sv
`timescale 1ns/1ps
module test_reglist_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hdr_mode = 1'b0, cfg_continuous = 1'b0;
    logic [31:0] cfg_list_addr = '0;
    logic [15:0] cfg_list_bytes = '0;
    logic        cfg_commit = 1'b0, cfg_start = 1'b0;
    logic        frame_start = 1'b0, frame_end = 1'b0;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        rb_wr;
    logic [31:0] rb_addr, rb_data;
    logic        upd_pending, busy, err_sticky, irq_done, irq_free;

    logic [63:0] mem [0:2047];
    logic [63:0] exp_q[$];
    int checks = 0, errors = 0, wr_cnt = 0, irq_cnt = 0;

    always #2.5 clk = ~clk;

    reglist_loader i_reglist_loader (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req;
            if (mem_req) mem_rdata <= mem[mem_addr[13:3]];
        end
    end

    // scoreboard monitor (R4 order/content)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rb_wr) begin
                logic [63:0] e;
                wr_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected write act=%h_%h exp=none", rb_data, rb_addr);
                end else begin
                    e = exp_q.pop_front();
                    if ({rb_data, rb_addr} !== e) begin
                        errors++;
                        $display("FAIL R4 write act=%h_%h exp=%h", rb_data, rb_addr, e);
                    end
                end
            end
            if (irq_done) irq_cnt++;
        end
    end

    task automatic check(input logic cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int base, input int n, input int seed);
        for (int i = 0; i < n; i++)
            mem[(base >> 3) + i] = {32'(seed << 16) | 32'(i), 32'h4000_0000 + 32'(seed << 12) + 32'(i * 4)};
    endtask

    task automatic expect_list(input int base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(mem[(base >> 3) + i]);
    endtask

    task automatic pulse_fe();
        @(negedge clk) frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
    endtask

    task automatic pulse_fs();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic commit(input logic [31:0] a, input logic [15:0] b);
        @(negedge clk) begin cfg_list_addr = a; cfg_list_bytes = b; cfg_commit = 1'b1; end
        @(negedge clk) cfg_commit = 1'b0;
    endtask

    task automatic start(input logic [31:0] a);
        @(negedge clk) begin cfg_list_addr = a; cfg_start = 1'b1; end
        @(negedge clk) cfg_start = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 5000) begin @(negedge clk); k++; end
        @(negedge clk);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, "expected writes left", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w0, i0;
        fill(32'h0100, 3, 1);
        fill(32'h0200, 2, 2);
        fill(32'h1000, 256, 3);
        fill(32'h0400, 2, 4);
        fill(32'h0500, 2, 5);
        // header 1: count 5, slot0 16B @0x400, slot1 16B @0x200, flags irq+auto
        mem[32'h3000 >> 3] = {32'd16, 32'd5};
        mem[(32'h3000 >> 3) + 1] = {32'd16, 32'h400};
        for (int i = 2; i < 9; i++) mem[(32'h3000 >> 3) + i] = {32'd8, 32'h200};
        mem[(32'h3000 >> 3) + 9] = {32'd0, 32'h3};
        // header 2: slot0 16B @0x500, flags clear
        mem[32'h3100 >> 3] = {32'd16, 32'd1};
        mem[(32'h3100 >> 3) + 1] = {32'd24, 32'h500};
        for (int i = 2; i < 9; i++) mem[(32'h3100 >> 3) + i] = '0;
        mem[(32'h3100 >> 3) + 9] = {32'hFFFF_FFFF, 32'h0};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !upd_pending && !err_sticky && !rb_wr && !mem_req && !irq_done && !irq_free,
              "R1", "reset outputs", {busy, upd_pending, err_sticky, rb_wr, mem_req, irq_done, irq_free}, 0);

        commit(32'h0100, 16'd24);
        check(upd_pending == 1'b1, "R2", "upd after commit", upd_pending, 1);
        commit(32'h0200, 16'd16);
        check(upd_pending && !busy && wr_cnt == 0, "R2", "second commit no effect", wr_cnt, 0);

        expect_list(32'h0100, 3);
        i0 = irq_cnt;
        pulse_fe();
        check(upd_pending == 1'b0, "R3", "upd cleared on take", upd_pending, 0);
        check(busy == 1'b1, "R10", "busy after take", busy, 1);
        wait_idle();
        drained("R4");
        check(irq_cnt == i0 + 1, "R8", "irq_done headerless", irq_cnt - i0, 1);
        check(busy == 1'b0, "R10", "busy low when idle", busy, 0);

        w0 = wr_cnt;
        pulse_fe();
        repeat (10) @(negedge clk);
        check(wr_cnt == w0 && !busy, "R3", "frame end without update", wr_cnt - w0, 0);

        pulse_fs();
        check(irq_free == 1'b1, "R11", "irq_free after frame start", irq_free, 1);
        pulse_fs();
        check(irq_free == 1'b0, "R11", "no second irq_free", irq_free, 0);

        cfg_continuous = 1'b1;
        expect_list(32'h0100, 3);
        pulse_fe();
        wait_idle();
        drained("R5");
        cfg_continuous = 1'b0;

        // commit and frame_end in the same cycle
        @(negedge clk) begin
            cfg_list_addr = 32'h0200; cfg_list_bytes = 16'd16;
            cfg_commit = 1'b1; frame_end = 1'b1;
        end
        @(negedge clk) begin cfg_commit = 1'b0; frame_end = 1'b0; end
        w0 = wr_cnt;
        repeat (6) @(negedge clk);
        check(upd_pending && !busy && wr_cnt == w0, "R3", "race commit not taken", upd_pending, 1);
        expect_list(32'h0200, 2);
        pulse_fe();
        wait_idle();
        drained("R3");

        // maximum list plus frame end while busy
        commit(32'h1000, 16'd2048);
        expect_list(32'h1000, 256);
        pulse_fe();
        check(busy == 1'b1, "R10", "busy on big list", busy, 1);
        commit(32'h0100, 16'd24);
        check(upd_pending == 1'b1, "R2", "commit accepted while busy", upd_pending, 1);
        pulse_fe();
        check(upd_pending == 1'b1, "R3", "frame end ignored while busy", upd_pending, 1);
        wait_idle();
        drained("R9");
        expect_list(32'h0100, 3);
        pulse_fe();
        wait_idle();
        drained("R3");

        // header mode
        cfg_hdr_mode = 1'b1;
        commit(32'h0200, 16'd16);
        check(upd_pending == 1'b0, "R2", "commit ignored in header mode", upd_pending, 0);
        i0 = irq_cnt;
        expect_list(32'h0400, 2);
        start(32'h3000);
        check(busy == 1'b1, "R10", "busy on header fetch", busy, 1);
        wait_idle();
        drained("R6");
        check(irq_cnt == i0 + 1, "R8", "irq_done with flag bit1", irq_cnt - i0, 1);

        i0 = irq_cnt;
        w0 = wr_cnt;
        start(32'h3100);
        repeat (20) @(negedge clk);
        check(busy && wr_cnt == w0, "R7", "waits for frame end", wr_cnt - w0, 0);
        expect_list(32'h0500, 2);
        pulse_fe();
        wait_idle();
        drained("R7");
        check(irq_cnt == i0, "R8", "no irq_done without flag bit1", irq_cnt - i0, 0);

        // bad lengths
        cfg_hdr_mode = 1'b0;
        check(err_sticky == 1'b0, "R9", "no error yet", err_sticky, 0);
        w0 = wr_cnt;
        commit(32'h0100, 16'd2056);
        pulse_fe();
        repeat (10) @(negedge clk);
        check(wr_cnt == w0 && err_sticky && !upd_pending, "R9", "oversize rejected", wr_cnt - w0, 0);
        commit(32'h0100, 16'd12);
        pulse_fe();
        repeat (10) @(negedge clk);
        check(wr_cnt == w0 && err_sticky, "R9", "non-multiple rejected", wr_cnt - w0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule